// File: doc/BRIEF.md
# Filtered Scanline Interrupt Counter

This block raises a scanline interrupt for a cartridge memory controller. It watches one address line of the video bus. That line goes high once per rendered line when the video chip switches from background to sprite pattern fetches. The block samples the line once per CPU bus cycle. A low-time filter decides whether a high level starts a new scanline or is only a short glitch inside the same line.

Each qualified scanline clocks an 8-bit down-counter. When the counter is at zero, it reloads and, if interrupts are enabled, requests an interrupt. The interrupt reaches the active-low output one bus cycle later. It then stays asserted until software acknowledges it.

Software reaches the block through four write ports, chosen by a 2-bit select:

| Select | Port | Effect |
|---|---|---|
| 0 | latch | Sets the reload value. |
| 1 | restart | Reloads the counter and parks the filter. |
| 2 | enable | Enables interrupts. |
| 3 | acknowledge | Disables and clears the interrupt. |

The `clk` input stands for the falling edge of the CPU bus clock. Every register update, including the register writes, happens on it.

Top module: `scan_irq_gen`

## Requirements
- R1: After a synchronous reset, `irq_n` is 1, interrupts are disabled, and the reload latch and the counter hold 0. The filter is parked, so the first high level of `vaddr_hi` after reset does not clock the counter.
- R2: Each cycle with `vaddr_hi` low raises the filter count by one, until it reaches 16, where it holds. A cycle with `vaddr_hi` high clocks the counter only if the filter count is exactly 16, and it always clears the filter to 0. A low time of 15 cycles therefore never clocks the counter, and a low time of 40 cycles clocks it exactly once.
- R3: On a counter clock, a count of 0 reloads from the latch and requests an interrupt; any other count decrements by one. After a restart write with latch value N, the interrupt request comes on the (N+1)-th qualified scanline.
- R4: A request drives `irq_n` low one cycle after the cycle in which it was made, whatever `vaddr_hi` does in that next cycle.
- R5: A write with `wr_sel`=0 stores `wr_data` as the reload value for later reloads. It leaves the running count unchanged.
- R6: A write with `wr_sel`=1 reloads the counter from the latch and parks the filter at 17. From there only a high cycle followed by 16 low cycles can rearm it. This write overrides the `vaddr_hi` filter update in the same cycle, even when `vaddr_hi` is high.
- R7: A write with `wr_sel`=2 enables interrupts. With interrupts disabled, a zero-count clock reloads the counter but never lowers `irq_n`.
- R8: A write with `wr_sel`=3 disables interrupts and clears both a pending request and an asserted `irq_n`. `irq_n` is 1 after that cycle.
- R9: Once low, `irq_n` stays low until a write with `wr_sel`=3, whatever further scanlines occur.
- R10: A cycle that carries a register write (other than `wr_sel`=1) with `vaddr_hi` low counts as an ordinary low cycle for the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one edge per CPU bus cycle, standing for the falling edge of the CPU bus clock |
| rst | input | 1 | Synchronous reset, active high |
| vaddr_hi | input | 1 | Sampled video address line used for scanline detection |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_sel | input | 2 | Register select: 0 latch, 1 restart, 2 enable, 3 acknowledge |
| wr_data | input | 8 | Write data; used by the latch port |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
A wrong filter count shows up as a shift in when `irq_n` falls, counted in scanlines:
- A filter that wraps instead of saturating loses a scanline after a long low time.
- A filter that is not parked gains one after a restart.

The wrong count becomes visible on the first zero-count clock after it goes wrong. That can be up to N+1 scanlines later, so the tests use small latch values to keep this short. A fault in the one-cycle delay stage shows within one cycle of the qualifying high level. A fault in the acknowledge or hold logic shows on the very next cycle.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
   typedef enum logic [1:0] {
      SEL_LATCH   = 2'd0,
      SEL_RESTART = 2'd1,
      SEL_ENABLE  = 2'd2,
      SEL_ACK     = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/line_filter.sv
// Low-time qualifier for the video address line. Count saturates at
// LIMIT while the line is low; PARK is a non-qualifying holding state.
module line_filter #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic park_i,
   input  logic line_hi_i,
   output logic tick_o
);
   localparam int PARK_I = LIMIT + 1;
   localparam int FW     = $clog2(PARK_I + 1);
   localparam logic [FW-1:0] LIM_V  = FW'(LIMIT);
   localparam logic [FW-1:0] PARK_V = FW'(PARK_I);

   initial assert (LIMIT >= 1) else $error("line_filter: LIMIT must be >= 1");

   logic [FW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || park_i)
         cnt_q <= PARK_V;
      else if (line_hi_i)
         cnt_q <= '0;
      else if (cnt_q < LIM_V)
         cnt_q <= cnt_q + FW'(1);
   end

   assign tick_o = line_hi_i && !park_i && (cnt_q == LIM_V);

   a_r2_hold_at_limit: assert property (@(posedge clk) disable iff (rst)
      (!park_i && !line_hi_i && cnt_q >= LIM_V) |=> cnt_q == $past(cnt_q));
   a_r2_clear_on_high: assert property (@(posedge clk) disable iff (rst)
      (!park_i && line_hi_i) |=> cnt_q == '0);
   a_r6_park_state: assert property (@(posedge clk) disable iff (rst)
      park_i |=> cnt_q == PARK_V);
endmodule

// File: rtl/line_counter.sv
// Scanline down-counter with reload on zero.
module line_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             zero_hit_o
);
   initial assert (CNT_W >= 1) else $error("line_counter: CNT_W must be >= 1");

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= reload_i;
      else if (tick_i)
         cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - CNT_W'(1);
   end

   assign zero_hit_o = tick_i && !load_i && (cnt_q == '0);

   a_r3_reload_on_zero: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !load_i && cnt_q == '0) |=> cnt_q == $past(reload_i));
   a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
   a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
      load_i |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen
   import scan_irq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int FILT_LIMIT = 16,
   parameter int IRQ_DELAY  = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vaddr_hi,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             irq_n
);
   initial assert (IRQ_DELAY == 0 || IRQ_DELAY == 1)
      else $error("scan_irq_gen: IRQ_DELAY must be 0 or 1");

   logic do_latch, do_restart, do_enable, do_ack;
   assign do_latch   = wr_en && (wr_sel == SEL_LATCH);
   assign do_restart = wr_en && (wr_sel == SEL_RESTART);
   assign do_enable  = wr_en && (wr_sel == SEL_ENABLE);
   assign do_ack     = wr_en && (wr_sel == SEL_ACK);

   logic [CNT_W-1:0] latch_q;
   logic             irq_en_q;
   logic             irq_q;
   logic             line_tick;
   logic             zero_hit;
   logic             req;

   always_ff @(posedge clk) begin
      if (rst)           latch_q <= '0;
      else if (do_latch) latch_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst || do_ack)  irq_en_q <= 1'b0;
      else if (do_enable) irq_en_q <= 1'b1;
   end

   line_filter #(.LIMIT(FILT_LIMIT)) i_filter (
      .clk       (clk),
      .rst       (rst),
      .park_i    (do_restart),
      .line_hi_i (vaddr_hi),
      .tick_o    (line_tick)
   );

   line_counter #(.CNT_W(CNT_W)) i_counter (
      .clk        (clk),
      .rst        (rst),
      .load_i     (do_restart),
      .tick_i     (line_tick),
      .reload_i   (latch_q),
      .zero_hit_o (zero_hit)
   );

   assign req = zero_hit && irq_en_q;

   generate
      if (IRQ_DELAY == 1) begin : g_delayed
         logic pend_q;
         always_ff @(posedge clk) begin
            if (rst || do_ack) pend_q <= 1'b0;
            else               pend_q <= req;
         end
         always_ff @(posedge clk) begin
            if (rst || do_ack) irq_q <= 1'b0;
            else if (pend_q)   irq_q <= 1'b1;
         end
         a_r4_one_cycle_late: assert property (@(posedge clk) disable iff (rst)
            (pend_q && !do_ack) |=> !irq_n);
         a_r4_not_early: assert property (@(posedge clk) disable iff (rst)
            (req && !irq_q) |=> irq_n);
      end else begin : g_direct
         always_ff @(posedge clk) begin
            if (rst || do_ack) irq_q <= 1'b0;
            else if (req)      irq_q <= 1'b1;
         end
      end
   endgenerate

   assign irq_n = ~irq_q;

   a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
      do_ack |=> irq_n);
   a_r9_held_low: assert property (@(posedge clk) disable iff (rst)
      (!irq_n && !do_ack) |=> !irq_n);
   a_r7_needs_enable: assert property (@(posedge clk) disable iff (rst)
      (!irq_en_q && irq_n && !do_enable) |=> ##1 irq_n);
endmodule

// File: tb/test_scan_irq_gen.sv
`timescale 1ns/1ps
module test_scan_irq_gen;
   import scan_irq_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       vaddr_hi = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       irq_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   scan_irq_gen i_scan_irq_gen (
      .clk(clk), .rst(rst), .vaddr_hi(vaddr_hi), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .irq_n(irq_n)
   );

   // One bus cycle: drive at negedge, result sampled 2 ns after the edge.
   task automatic step(input logic hi, input logic we, input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      vaddr_hi = hi; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk);
      #2;
   endtask

   task automatic lows(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic highs(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
   endtask

   task automatic line(input int lo, input int hi);
      lows(lo);
      highs(hi);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      step(1'b0, 1'b1, sel, d);
   endtask

   task automatic chk(input string tag, input logic exp);
      checks++;
      if (irq_n !== exp) begin
         fails++;
         $display("FAIL %s: irq_n=%b expected %b", tag, irq_n, exp);
      end
   endtask

   // restart with latch n, enable, one high cycle to leave the parked state
   task automatic arm(input logic [7:0] n);
      wr(SEL_ACK, 8'd0);
      wr(SEL_LATCH, n);
      wr(SEL_RESTART, 8'd0);
      wr(SEL_ENABLE, 8'd0);
      highs(1);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) step(1'b0, 1'b0, 2'd0, 8'd0);
      rst = 1'b0;
      chk("R1 reset irq_n high", 1'b1);
      wr(SEL_ENABLE, 8'd0);
      line(20, 1);
      lows(1);
      chk("R1 parked filter gives no clock", 1'b1);
      line(15, 1);
      chk("R4 request not visible in same cycle", 1'b1);
      lows(1);
      chk("R4 irq_n low one cycle later", 1'b0);
      lows(30);
      line(16, 1);
      lows(5);
      chk("R9 irq_n held low", 1'b0);
   endtask

   task automatic t_ack;
      wr(SEL_ACK, 8'd0);
      chk("R8 ack releases irq_n", 1'b1);
      line(16, 1);
      lows(2);
      chk("R7 disabled zero clock gives no irq", 1'b1);
   endtask

   task automatic t_count(input logic [7:0] n, input int hi_len);
      arm(n);
      for (int i = 0; i < n; i++) line(16, hi_len);
      lows(1);
      chk("R3 no irq after N scanlines", 1'b1);
      line(16, hi_len);
      lows(1);
      chk("R3 R7 irq after N+1 scanlines", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_short;
      arm(8'd0);
      for (int i = 0; i < 5; i++) line(15, 1);
      lows(1);
      chk("R2 15-cycle low never clocks", 1'b1);
      line(16, 1);
      lows(1);
      chk("R2 16-cycle low clocks", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_long;
      arm(8'd1);
      line(40, 1);
      lows(1);
      chk("R2 long low clocks once", 1'b1);
      line(40, 1);
      lows(1);
      chk("R2 saturated filter clocks again", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_latch;
      arm(8'd2);
      line(16, 1);
      wr(SEL_LATCH, 8'd7);
      line(16, 1);
      lows(1);
      chk("R5 latch write leaves count", 1'b1);
      line(16, 1);
      lows(1);
      chk("R5 old count expires", 1'b0);
      wr(SEL_ACK, 8'd0);
      wr(SEL_ENABLE, 8'd0);
      for (int i = 0; i < 7; i++) line(16, 1);
      lows(1);
      chk("R5 new value not yet expired", 1'b1);
      line(16, 1);
      lows(1);
      chk("R5 new reload value used", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_restart_mid;
      arm(8'd0);
      lows(16);
      wr(SEL_RESTART, 8'd0);
      highs(1);
      lows(1);
      chk("R6 restart parks armed filter", 1'b1);
      line(16, 1);
      lows(1);
      chk("R6 rearmed after high and 16 lows", 1'b0);
      wr(SEL_ACK, 8'd0);
      arm(8'd0);
      lows(16);
      step(1'b1, 1'b1, SEL_RESTART, 8'd0);
      lows(1);
      chk("R6 restart beats high level", 1'b1);
      line(16, 1);
      lows(1);
      chk("R6 filter stayed parked", 1'b1);
      line(16, 1);
      lows(1);
      chk("R6 clocks after real clear", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_write_cycles;
      arm(8'd0);
      lows(8);
      for (int i = 0; i < 7; i++) wr(SEL_LATCH, 8'd0);
      highs(1);
      lows(1);
      chk("R10 15 cycles with writes too short", 1'b1);
      lows(9);
      for (int i = 0; i < 7; i++) wr(SEL_LATCH, 8'd0);
      highs(1);
      lows(1);
      chk("R10 write cycles count as low cycles", 1'b0);
      wr(SEL_ACK, 8'd0);
   endtask

   task automatic t_ack_pending;
      arm(8'd0);
      line(16, 1);
      wr(SEL_ACK, 8'd0);
      chk("R8 ack cancels pending request", 1'b1);
      lows(1);
      chk("R8 request stays cancelled", 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_ack();
      t_count(8'd3, 1);
      t_count(8'd0, 1);
      t_count(8'd5, 3);
      t_short();
      t_long();
      t_latch();
      t_restart_mid();
      t_write_cycles();
      t_ack_pending();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule